// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of one memory burst. A column command (the start strobe) hands it a starting column, a burst length code and an ordering mode. From the next cycle on, the block drives one column per cycle until the burst has run its length, with no further address input. It marks the final beat of a finite burst with a last-beat flag and drops its valid flag on the cycle after that beat.

Two orderings are provided. Sequential order counts upward inside the aligned block that the burst length defines. Interleaved order XORs the beat index into the low bits of the start column. A full-page burst walks all 256 columns, wrapping modulo 256. It runs until a terminate strobe or a new column command ends it.

A new column command is accepted on any cycle and replaces the burst in progress. The clock enable freezes the whole block. The block sits in the command path of a memory controller. Its inputs and outputs are plain control signals with no back-pressure: a consumer that cannot take a column holds the clock enable low.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, col_valid and last_beat are 0 and col is 0.
- R2: When cmd_start is 1 with cke 1, on the next cycle col_valid is 1, col equals the start_col sampled with the command, and the beat index restarts at 0.
- R3: len_code 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. last_beat is 1 exactly while the final beat is presented. After that beat is taken with cke 1, col_valid is 0 unless a new command starts.
- R4: With order_mode 0 (sequential), beat k presents the upper bits of the start column unchanged. Its low log2(BL) bits equal the start column's low bits plus k, modulo BL.
- R5: With order_mode 1 (interleaved), beat k presents the upper bits of the start column unchanged. Its low log2(BL) bits equal the start column's low bits XOR k.
- R6: len_code 7 selects a full-page burst: beat k is start_col plus k modulo 256, whatever order_mode is. last_beat never rises, and the burst stays valid until ended by cmd_term or cmd_start.
- R7: cmd_term with cke 1 clears col_valid on the next cycle. When cmd_start and cmd_term are both 1, the start wins.
- R8: A cmd_start during a burst abandons the old burst. The next cycle presents the new start column as beat 0 of the new length and order.
- R9: While cke is 0, col, col_valid and last_beat hold their values, the beat index does not advance, and cmd_start and cmd_term are ignored.
- R10: The reserved len_code values 4, 5 and 6 behave as a burst of 1 beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; 0 freezes the block |
| cmd_start | input | 1 | Column command: load a new burst |
| cmd_term | input | 1 | End the current burst |
| start_col | input | 8 | Start column sampled with cmd_start |
| len_code | input | 3 | Burst length code (0..3: 1/2/4/8, 7: full page, others: 1) |
| order_mode | input | 1 | 0 sequential, 1 interleaved |
| col | output | 8 | Column of the current beat |
| col_valid | output | 1 | A burst beat is being presented |
| last_beat | output | 1 | Current beat is the final beat of a finite burst |

## Verification
The bench builds the block with its default parameters: 8-bit columns, 3-bit length codes, code 7 for full page and lengths up to 8. Those defaults reach the 256-column wrap of a full-page burst within a few hundred cycles. With 8-bit columns, random start columns land on every alignment of the 2-, 4- and 8-beat blocks, so both orderings wrap inside their block from every starting offset. The reserved codes and the start-over-terminate priority are also reachable with these values.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_INTLV = 1'b1} order_e;

  typedef struct packed {
    logic [7:0] mask;
    logic       full;
    logic       seq;
  } burst_shape_t;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
  parameter int COL_W     = 8,
  parameter int CODE_W    = 3,
  parameter int MAX_LOG2  = 3,
  parameter int FULL_CODE = 7
) (
  input  logic [CODE_W-1:0] len_code,
  input  logic              order_mode,
  output logic [COL_W-1:0]  mask,
  output logic              full,
  output logic              seq
);
  import burst_col_pkg::*;

  always_comb begin
    mask = '0;
    full = 1'b0;
    if (len_code == CODE_W'(FULL_CODE)) begin
      mask = '1;
      full = 1'b1;
    end else begin
      for (int k = 0; k <= MAX_LOG2; k++) begin
        if (len_code == CODE_W'(k)) mask = COL_W'((1 << k) - 1);
      end
    end
    // full page always counts sequentially
    seq = full || (order_mode == ORD_SEQ);
  end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             seq,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;
  assign sum = base + beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    always_comb begin
      if (!mask[i])  col[i] = base[i];
      else if (seq)  col[i] = sum[i];
      else           col[i] = base[i] ^ beat[i];
    end
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cmd_start,
  input  logic             cmd_term,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  logic             seq_in,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] beat_q,
  output logic [COL_W-1:0] mask_q,
  output logic             full_q,
  output logic             seq_q,
  output logic             valid_q,
  output logic             last
);
  assign last = valid_q && !full_q && (beat_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      seq_q   <= 1'b1;
      valid_q <= 1'b0;
    end else if (cke) begin
      if (cmd_start) begin
        base_q  <= start_col;
        beat_q  <= '0;
        mask_q  <= mask_in;
        full_q  <= full_in;
        seq_q   <= seq_in;
        valid_q <= 1'b1;
      end else if (cmd_term) begin
        valid_q <= 1'b0;
      end else if (valid_q) begin
        if (last) valid_q <= 1'b0;
        else      beat_q  <= beat_q + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W     = 8,
  parameter int CODE_W    = 3,
  parameter int MAX_LOG2  = 3,
  parameter int FULL_CODE = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cmd_start,
  input  logic              cmd_term,
  input  logic [COL_W-1:0]  start_col,
  input  logic [CODE_W-1:0] len_code,
  input  logic              order_mode,
  output logic [COL_W-1:0]  col,
  output logic              col_valid,
  output logic              last_beat
);
  logic [COL_W-1:0] dec_mask, base_q, beat_q, mask_q;
  logic             dec_full, dec_seq, burst_full, seq_q;

  burst_len_decode #(.COL_W(COL_W), .CODE_W(CODE_W), .MAX_LOG2(MAX_LOG2),
                     .FULL_CODE(FULL_CODE)) u_dec (
    .len_code  (len_code),
    .order_mode(order_mode),
    .mask      (dec_mask),
    .full      (dec_full),
    .seq       (dec_seq)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .cmd_start(cmd_start),
    .cmd_term (cmd_term),
    .start_col(start_col),
    .mask_in  (dec_mask),
    .full_in  (dec_full),
    .seq_in   (dec_seq),
    .base_q   (base_q),
    .beat_q   (beat_q),
    .mask_q   (mask_q),
    .full_q   (burst_full),
    .seq_q    (seq_q),
    .valid_q  (col_valid),
    .last     (last_beat)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base(base_q),
    .beat(beat_q),
    .mask(mask_q),
    .seq (seq_q),
    .col (col)
  );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cmd_start,
  input logic             cmd_term,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col,
  input logic             col_valid,
  input logic             last_beat,
  input logic             burst_full
);
  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cmd_start) |=> (col_valid && col == $past(start_col)));

  // R3
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && last_beat && !cmd_start) |=> !col_valid);

  // R3
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_valid);

  // R6
  full_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && burst_full) |-> !last_beat);

  // R6
  full_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && col_valid && burst_full && !cmd_term) |=> col_valid);

  // R7
  term_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cmd_term && !cmd_start) |=> !col_valid);

  // R9
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(col) && $stable(col_valid) && $stable(last_beat)));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cmd_start (cmd_start),
  .cmd_term  (cmd_term),
  .start_col (start_col),
  .col       (col),
  .col_valid (col_valid),
  .last_beat (last_beat),
  .burst_full(burst_full)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1;
  logic       cmd_start = 1'b0;
  logic       cmd_term = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       order_mode = 1'b0;
  logic [7:0] col;
  logic       col_valid, last_beat;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // expected-state model
  bit       m_valid = 0;
  int       m_beat = 0;
  int       m_len = 1;
  bit       m_full = 0;
  bit       m_seq = 1;
  logic [7:0] m_start = '0;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_start(cmd_start),
    .cmd_term(cmd_term), .start_col(start_col), .len_code(len_code),
    .order_mode(order_mode), .col(col), .col_valid(col_valid),
    .last_beat(last_beat)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int len_of(input logic [2:0] code);
    if (code == 3'd7) return 256;
    if (code <= 3'd3) return 1 << code;
    return 1;
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int k,
                                         input int len, input bit sq);
    logic [7:0] m, kb;
    m  = 8'(len - 1);
    kb = 8'(k);
    if (sq) return (s & ~m) | ((s + kb) & m);
    return (s & ~m) | ((s ^ kb) & m);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    bit e_last;
    e_last = m_valid && !m_full && (m_beat == m_len - 1);
    chk({tag, " valid"}, int'(col_valid), int'(m_valid));
    chk({tag, " last"}, int'(last_beat), int'(e_last));
    if (m_valid) chk({tag, " col"}, int'(col), int'(exp_col(m_start, m_beat, m_len, m_seq)));
  endtask

  // drive at negedge, advance model, check at next negedge
  task automatic step(input string tag, input bit st, input bit tm, input bit ce,
                      input logic [7:0] sc, input logic [2:0] lc, input bit om);
    cmd_start = st; cmd_term = tm; cke = ce;
    start_col = sc; len_code = lc; order_mode = om;
    if (ce) begin
      if (st) begin
        m_valid = 1; m_beat = 0; m_start = sc; m_len = len_of(lc);
        m_full = (lc == 3'd7); m_seq = m_full || !om;
      end else if (tm) begin
        m_valid = 0;
      end else if (m_valid) begin
        if (m_full) m_beat = (m_beat + 1) % 256;
        else if (m_beat == m_len - 1) m_valid = 0;
        else m_beat++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 1, 8'h00, 3'd0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 valid", int'(col_valid), 0);
    chk("R1 last", int'(last_beat), 0);
    chk("R1 col", int'(col), 0);

    // R2 R3 R4: length 4 sequential from 0x1E -> 1E 1F 1C 1D
    step("R2 R4 bl4 seq", 1, 0, 1, 8'h1E, 3'd2, 0);
    chk("R2 first col", int'(col), 8'h1E);
    idle("R3 R4 bl4 seq", 3);
    chk("R3 last at 4th", int'(last_beat), 1);
    chk("R4 4th col", int'(col), 8'h1D);
    idle("R3 after end", 2);

    // R5: length 8 interleaved from 0x35
    step("R5 bl8 intlv", 1, 0, 1, 8'h35, 3'd3, 1);
    idle("R5 bl8 intlv", 4);
    chk("R5 5th col", int'(col), 8'h31);
    idle("R5 bl8 intlv", 5);

    // R3: length 1 and 2
    step("R3 bl1", 1, 0, 1, 8'h7F, 3'd0, 0);
    chk("R3 bl1 last", int'(last_beat), 1);
    idle("R3 bl1", 1);
    step("R3 bl2 intlv", 1, 0, 1, 8'h81, 3'd1, 1);
    idle("R3 bl2", 2);

    // R10 reserved codes
    for (int c = 4; c <= 6; c++) begin
      step("R10 reserved", 1, 0, 1, 8'h42, 3'(c), 0);
      chk("R10 last", int'(last_beat), 1);
      idle("R10 reserved", 1);
    end

    // R6: full page from 0xFE, order ignored, wraps through 0
    step("R6 full", 1, 0, 1, 8'hFE, 3'd7, 1);
    idle("R6 full", 2);
    chk("R6 wrap col", int'(col), 8'h00);
    idle("R6 full", 260);
    chk("R6 still valid", int'(col_valid), 1);
    // R7 terminate
    step("R7 term", 0, 1, 1, 8'h00, 3'd0, 0);
    chk("R7 cleared", int'(col_valid), 0);

    // R8 restart mid-burst
    step("R8 first", 1, 0, 1, 8'h10, 3'd3, 0);
    idle("R8 first", 2);
    step("R8 restart", 1, 0, 1, 8'hC6, 3'd2, 1);
    chk("R8 new col", int'(col), 8'hC6);
    idle("R8 new burst", 4);

    // R7 start wins over term
    step("R7 start+term", 1, 1, 1, 8'h55, 3'd2, 0);
    chk("R7 start wins", int'(col_valid), 1);
    idle("R7 tail", 4);

    // R9 cke low holds and ignores commands
    step("R9 setup", 1, 0, 1, 8'h23, 3'd3, 0);
    idle("R9 setup", 2);
    step("R9 hold start", 1, 0, 0, 8'h99, 3'd0, 1);
    chk("R9 col held", int'(col), 8'h25);
    step("R9 hold term", 0, 1, 0, 8'h00, 3'd0, 0);
    chk("R9 valid held", int'(col_valid), 1);
    idle("R9 resume", 6);

    // random mix: R2 R3 R4 R5 R6 R7 R8 R9 R10
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 6000; i++) begin
      bit st, tm, ce;
      logic [2:0] lc;
      st = ($urandom % 8) == 0;
      tm = ($urandom % 24) == 0;
      ce = ($urandom % 6) != 0;
      lc = ($urandom % 5 == 0) ? 3'd7 : 3'($urandom % 8);
      step("R4 R5 R6 R9 random", st, tm, ce, 8'($urandom), lc, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule